// File: doc/BRIEF.md
# Predict-Taken Branch Fetch Controller

This block owns the fetch program counter of a five-stage in-order pipeline and applies a fixed guess that every branch-on-zero is taken. The word coming back from instruction memory is decoded in the same cycle it arrives. When its opcode marks a branch, fetch jumps straight to the target, with no wait for any ALU status. The sequential address (current PC plus one instruction) is driven out every cycle so that the surrounding pipeline can carry it down alongside the instruction.

The guess is checked when the branch reaches execute. The pipeline returns three things: a flag saying a branch sits in execute, the zero result for its operand, and the fall-through address that travelled with it. A nonzero operand means the guess was wrong. In that case the block points fetch back at the carried fall-through address. In the same cycle it raises squash controls for the fetch/decode and decode/execute buffers, so that both wrong-path slots are loaded with a harmless no-op word instead. The block also supplies that no-op word, which writes only register 0.

Top module: `pfc_fetch_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `pc_o` is 0 and both squash outputs are low.
- R2: When the fetched word is not a branch (opcode field, bits 31:26, differs from 6'h04) and no misprediction is signalled, `next_pc_o` equals `pc_o + 4`.
- R3: When the fetched word has opcode 6'h04 and no misprediction is signalled, `next_pc_o` equals `pc_o` plus the sign-extended bits 15:0 shifted left by two. This holds for backward and extreme offsets.
- R4: `fallthru_pc_o` equals `pc_o + 4` in every cycle.
- R5: When `ex_is_branch_i` is high and `ex_zero_i` is low, `next_pc_o` equals `ex_fallthru_pc_i`, and `ifid_squash_o` and `idex_squash_o` are both high in that cycle.
- R6: When no branch is in execute, or the branch in execute has a zero operand, both squash outputs stay low and a correctly predicted branch costs no fetch bubbles.
- R7: A misprediction in execute takes priority over a branch decoded from the fetched word in the same cycle.
- R8: `nop_word_o` is constantly 32'h0000_0021, a move of register 0 into register 0.
- R9: At every rising clock edge out of reset, `pc_o` takes the value `next_pc_o` held before the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_word_i | input | 32 | Instruction word read at `pc_o` |
| ex_is_branch_i | input | 1 | A branch-on-zero occupies the execute stage |
| ex_zero_i | input | 1 | Execute-stage operand of that branch is zero |
| ex_fallthru_pc_i | input | 32 | Sequential address carried down with the branch in execute |
| pc_o | output | 32 | Current fetch address |
| next_pc_o | output | 32 | Address to be fetched next cycle |
| fallthru_pc_o | output | 32 | Sequential address of the word now being fetched |
| ifid_squash_o | output | 1 | Load a no-op into the fetch/decode buffer |
| idex_squash_o | output | 1 | Load a no-op into the decode/execute buffer |
| nop_word_o | output | 32 | Instruction word used for squashed slots |

## Verification
The properties assume that the execute-side inputs come from a pipeline that the block itself feeds. The branch flag must be low in the first cycle after reset, and the carried fall-through value must be one that this block produced. The bench meets both conditions by modelling the two inter-stage buffers around the block. These buffers reset to the no-op word, carry `fallthru_pc_o` forward, and take the execute zero flag from a bench-only bit of the branch word. The expected fetch traces, including the wrong-path addresses and the cycle in which squash fires, are written out by hand from the requirements.

// File: rtl/pfc_pkg.sv
package pfc_pkg;

    localparam int unsigned PFC_XLEN = 32;
    localparam int unsigned PFC_ILEN = 32;

    typedef logic [PFC_XLEN-1:0] addr_t;
    typedef logic [PFC_ILEN-1:0] word_t;

    typedef enum logic [1:0] {
        SRC_SEQ     = 2'd0,
        SRC_PRED    = 2'd1,
        SRC_RECOVER = 2'd2
    } pc_src_e;

    typedef struct packed {
        addr_t pc;
    } pfc_state_t;

endpackage

// File: rtl/pfc_br_decode.sv
module pfc_br_decode
    import pfc_pkg::*;
#(
    parameter int unsigned     OPC_W    = 6,
    parameter int unsigned     OPC_LSB  = 26,
    parameter int unsigned     IMM_W    = 16,
    parameter logic [OPC_W-1:0] BR_OPC  = 6'h04,
    parameter int unsigned     ALIGN_SH = 2
) (
    input  logic [PFC_ILEN-1:0] word_i,
    input  logic [PFC_XLEN-1:0] pc_i,
    output logic                hit_o,
    output logic [PFC_XLEN-1:0] target_o
);
    localparam int unsigned EXT_W = PFC_XLEN - IMM_W;

    logic [OPC_W-1:0]    opcode;
    logic [IMM_W-1:0]    imm;
    logic [PFC_XLEN-1:0] offset;
    logic                unused_mid;

    assign opcode     = word_i[OPC_LSB +: OPC_W];
    assign imm        = word_i[IMM_W-1:0];
    assign unused_mid = ^word_i[OPC_LSB-1:IMM_W];

    // Decision on opcode only: no ALU status is consulted here.
    assign hit_o    = (opcode == BR_OPC);
    assign offset   = {{EXT_W{imm[IMM_W-1]}}, imm} << ALIGN_SH;
    assign target_o = pc_i + offset;

endmodule

// File: rtl/pfc_resolve.sv
module pfc_resolve #(
    parameter int unsigned SLOTS = 2
) (
    input  logic             ex_branch_i,
    input  logic             ex_zero_i,
    output logic             mispredict_o,
    output logic [SLOTS-1:0] squash_o
);
    // Guess was "taken"; a nonzero operand proves it wrong.
    assign mispredict_o = ex_branch_i & ~ex_zero_i;

    generate
        for (genvar g = 0; g < SLOTS; g++) begin : g_slot
            assign squash_o[g] = mispredict_o;
        end
    endgenerate

endmodule

// File: rtl/pfc_pc_select.sv
module pfc_pc_select
    import pfc_pkg::*;
(
    input  logic [PFC_XLEN-1:0] seq_pc_i,
    input  logic [PFC_XLEN-1:0] pred_pc_i,
    input  logic [PFC_XLEN-1:0] recover_pc_i,
    input  logic                pred_hit_i,
    input  logic                mispredict_i,
    output logic [PFC_XLEN-1:0] next_pc_o
);
    pc_src_e src;

    always_comb begin
        if (mispredict_i) begin
            src = SRC_RECOVER;
        end else if (pred_hit_i) begin
            src = SRC_PRED;
        end else begin
            src = SRC_SEQ;
        end
    end

    always_comb begin
        unique case (src)
            SRC_RECOVER: next_pc_o = recover_pc_i;
            SRC_PRED:    next_pc_o = pred_pc_i;
            default:     next_pc_o = seq_pc_i;
        endcase
    end

endmodule

// File: rtl/pfc_fetch_ctrl.sv
module pfc_fetch_ctrl
    import pfc_pkg::*;
#(
    parameter int unsigned      OPC_W    = 6,
    parameter int unsigned      OPC_LSB  = 26,
    parameter int unsigned      IMM_W    = 16,
    parameter logic [OPC_W-1:0] BR_OPC   = 6'h04,
    parameter logic [31:0]      NOP_WORD = 32'h0000_0021
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [PFC_ILEN-1:0] fetch_word_i,
    input  logic                ex_is_branch_i,
    input  logic                ex_zero_i,
    input  logic [PFC_XLEN-1:0] ex_fallthru_pc_i,
    output logic [PFC_XLEN-1:0] pc_o,
    output logic [PFC_XLEN-1:0] next_pc_o,
    output logic [PFC_XLEN-1:0] fallthru_pc_o,
    output logic                ifid_squash_o,
    output logic                idex_squash_o,
    output logic [PFC_ILEN-1:0] nop_word_o
);
    localparam int unsigned INSTR_BYTES = PFC_ILEN / 8;
    localparam int unsigned ALIGN_SH    = $clog2(INSTR_BYTES);
    localparam int unsigned SLOTS       = 2;

    pfc_state_t          state_d, state_q;
    logic                pred_hit;
    logic [PFC_XLEN-1:0] pred_pc;
    logic [PFC_XLEN-1:0] seq_pc;
    logic [PFC_XLEN-1:0] sel_pc;
    logic                mispredict;
    logic [SLOTS-1:0]    squash;

    assign seq_pc = state_q.pc + PFC_XLEN'(INSTR_BYTES);

    pfc_br_decode #(
        .OPC_W   (OPC_W),
        .OPC_LSB (OPC_LSB),
        .IMM_W   (IMM_W),
        .BR_OPC  (BR_OPC),
        .ALIGN_SH(ALIGN_SH)
    ) u_decode (
        .word_i  (fetch_word_i),
        .pc_i    (state_q.pc),
        .hit_o   (pred_hit),
        .target_o(pred_pc)
    );

    pfc_resolve #(
        .SLOTS(SLOTS)
    ) u_resolve (
        .ex_branch_i (ex_is_branch_i),
        .ex_zero_i   (ex_zero_i),
        .mispredict_o(mispredict),
        .squash_o    (squash)
    );

    pfc_pc_select u_select (
        .seq_pc_i    (seq_pc),
        .pred_pc_i   (pred_pc),
        .recover_pc_i(ex_fallthru_pc_i),
        .pred_hit_i  (pred_hit),
        .mispredict_i(mispredict),
        .next_pc_o   (sel_pc)
    );

    always_comb begin
        state_d    = state_q;
        state_d.pc = sel_pc;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign pc_o          = state_q.pc;
    assign next_pc_o     = state_d.pc;
    assign fallthru_pc_o = seq_pc;
    assign ifid_squash_o = squash[0];
    assign idex_squash_o = squash[SLOTS-1];
    assign nop_word_o    = NOP_WORD;

endmodule

// File: rtl/pfc_fetch_ctrl_chk.sv
module pfc_fetch_ctrl_chk
    import pfc_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                ex_is_branch_i,
    input logic                ex_zero_i,
    input logic [PFC_XLEN-1:0] ex_fallthru_pc_i,
    input logic [PFC_XLEN-1:0] pc_o,
    input logic [PFC_XLEN-1:0] next_pc_o,
    input logic [PFC_XLEN-1:0] fallthru_pc_o,
    input logic                ifid_squash_o,
    input logic                idex_squash_o
);
    logic seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
        end else begin
            seen_q <= 1'b1;
        end
    end

    assert_reset_pc_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_q |-> (pc_o == '0));

    assert_fallthru_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fallthru_pc_o == pc_o + PFC_XLEN'(4));

    assert_recover_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_is_branch_i && !ex_zero_i) |->
            (next_pc_o == ex_fallthru_pc_i && ifid_squash_o && idex_squash_o));

    assert_no_squash_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(ex_is_branch_i && !ex_zero_i) |-> (!ifid_squash_o && !idex_squash_o));

    assert_pc_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q |-> (pc_o == $past(next_pc_o)));

endmodule

bind pfc_fetch_ctrl pfc_fetch_ctrl_chk chk_i (.*);

// File: tb/pfc_fetch_ctrl_tb.sv
module pfc_fetch_ctrl_tb_top;
    import pfc_pkg::*;

    localparam logic [31:0] ALU_W = 32'h2000_0000;
    localparam logic [31:0] NOP_W = 32'h0000_0021;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] fetch_word, pc_o, next_pc_o, fallthru_pc_o, nop_word_o;
    logic        ex_br, ex_zero, ifid_squash_o, idex_squash_o;
    logic [31:0] ex_ft;
    logic [31:0] ifid_w, ifid_ft, idex_w, idex_ft;
    logic [31:0] mem [0:63];
    logic        mon_on = 1'b0;
    logic [31:0] prev_next;
    logic        prev_ok = 1'b0;
    int          n_chk = 0;
    int          n_fail = 0;

    typedef struct {
        logic [31:0] pc;
        logic        sq;
        string       tag;
    } exp_t;
    exp_t sb_q[$];

    always #4 clk = ~clk;

    pfc_fetch_ctrl dut_i (
        .clk             (clk),
        .rst_n           (rst_n),
        .fetch_word_i    (fetch_word),
        .ex_is_branch_i  (ex_br),
        .ex_zero_i       (ex_zero),
        .ex_fallthru_pc_i(ex_ft),
        .pc_o            (pc_o),
        .next_pc_o       (next_pc_o),
        .fallthru_pc_o   (fallthru_pc_o),
        .ifid_squash_o   (ifid_squash_o),
        .idex_squash_o   (idex_squash_o),
        .nop_word_o      (nop_word_o)
    );

    always_comb begin
        if (pc_o < 32'd256) fetch_word = mem[pc_o[7:2]];
        else                fetch_word = ALU_W;
    end

    // Two inter-stage buffers; bit 21 of a branch word is the bench's zero flag.
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ifid_w <= NOP_W; ifid_ft <= '0; idex_w <= NOP_W; idex_ft <= '0;
        end else begin
            ifid_w  <= ifid_squash_o ? NOP_W : fetch_word;
            ifid_ft <= fallthru_pc_o;
            idex_w  <= idex_squash_o ? NOP_W : ifid_w;
            idex_ft <= ifid_ft;
        end
    end
    assign ex_br   = (idex_w[31:26] == 6'h04);
    assign ex_zero = idex_w[21];
    assign ex_ft   = idex_ft;

    function automatic logic [31:0] br(input logic taken, input int off);
        logic [31:0] o = off;
        return {6'h04, 4'b0, taken, 5'b0, o[15:0]};
    endfunction

    task automatic push(input logic [31:0] pc, input logic sq, input string tag);
        exp_t e;
        e.pc = pc; e.sq = sq; e.tag = tag;
        sb_q.push_back(e);
    endtask

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: pops one expected item per cycle once running.
    always @(negedge clk) begin
        if (mon_on && sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            check(pc_o === e.pc, {e.tag, " pc"}, pc_o, e.pc);
            check(ifid_squash_o === e.sq && idex_squash_o === e.sq, {e.tag, " squash"},
                  {30'b0, ifid_squash_o, idex_squash_o}, {30'b0, e.sq, e.sq});
            check(fallthru_pc_o === pc_o + 32'd4, "R4 fallthru", fallthru_pc_o, pc_o + 32'd4);
            if (prev_ok)
                check(pc_o === prev_next, "R9 pc follows next", pc_o, prev_next);
            prev_next = next_pc_o;
            prev_ok   = 1'b1;
        end
    end

    task automatic clear_mem();
        for (int i = 0; i < 64; i++) mem[i] = ALU_W;
    endtask

    task automatic run_trace();
        @(posedge clk);
        #1 rst_n = 1'b1; mon_on = 1'b1;
        wait (sb_q.size() == 0);
        @(posedge clk);
        #1 mon_on = 1'b0; rst_n = 1'b0; prev_ok = 1'b0;
        repeat (2) @(posedge clk);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", n_chk, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        clear_mem();
        repeat (3) @(negedge clk);
        check(pc_o === 32'd0, "R1 reset pc", pc_o, 0);
        check(!ifid_squash_o && !idex_squash_o, "R1 reset squash",
              {30'b0, ifid_squash_o, idex_squash_o}, 0);
        check(nop_word_o === NOP_W, "R8 nop word", nop_word_o, NOP_W);

        // Taken branch at 4, offset +3: no bubbles (R3, R6).
        clear_mem(); mem[1] = br(1'b1, 3);
        push(0, 0, "R1"); push(4, 0, "R2"); push(16, 0, "R3"); push(20, 0, "R6");
        push(24, 0, "R6"); push(28, 0, "R2");
        run_trace();

        // Not-taken branch at 4: two squashed slots, fetch restored to 8 (R5).
        clear_mem(); mem[1] = br(1'b0, 3);
        push(0, 0, "R1"); push(4, 0, "R2"); push(16, 0, "R3"); push(20, 1, "R5");
        push(8, 0, "R5"); push(12, 0, "R2"); push(16, 0, "R2"); push(20, 0, "R6");
        run_trace();

        // Misprediction coincides with a fetched branch at 20 (R7).
        clear_mem(); mem[1] = br(1'b0, 3); mem[5] = br(1'b1, -5);
        push(0, 0, "R1"); push(4, 0, "R2"); push(16, 0, "R3"); push(20, 1, "R7");
        push(8, 0, "R7"); push(12, 0, "R2"); push(16, 0, "R2"); push(20, 0, "R2");
        push(0, 0, "R3"); push(4, 0, "R6");
        run_trace();

        // Most negative offset: target 0xFFFE0000 (R3).
        clear_mem(); mem[0] = br(1'b1, -32768);
        push(0, 0, "R1"); push(32'hFFFE_0000, 0, "R3"); push(32'hFFFE_0004, 0, "R6");
        push(32'hFFFE_0008, 0, "R2");
        run_trace();

        // Back-to-back branches, second mispredicted (R5).
        clear_mem(); mem[0] = br(1'b1, 2); mem[2] = br(1'b0, 4);
        push(0, 0, "R1"); push(8, 0, "R3"); push(24, 0, "R3"); push(28, 1, "R5");
        push(12, 0, "R5"); push(16, 0, "R2");
        run_trace();

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule